// File: doc/BRIEF.md
# Edge Interrupt Aggregator with Clear-on-Read

This block watches a group of already-synchronized input lines, turns programmed transitions on them into sticky event bits, and folds those bits into two active-high interrupt request lines meant for two separate hosts. Each line can be set to react to rising transitions, falling transitions, both, or neither. Detection is purely edge based: a line sitting at a constant level never produces an event.

Software reaches the block through a small byte-wide register port. It configures the edge selection, two per-line mask vectors and a control byte, and it reads the event status. In clear-on-read mode the act of reading a status byte acknowledges the bits it returned; otherwise status bits are acknowledged by writing ones to them. A control bit decides whether an event on a masked line is still recorded, and another decides whether the second interrupt line mirrors the first or is gated by its own mask vector.

Top module: `edge_irq_agg`

## Requirements
- R1: Line n is configured in edge register at address n>>2 (addresses 0x00 to 0x04 for 18 lines), field bits [(n&3)*2+1 : (n&3)*2]; the upper field bit enables rising detection and the lower enables falling detection, 2'b11 detects both transitions and 2'b00 none. Edge registers read back as written and reset to zero.
- R2: A line held at a constant level never sets its status bit, whatever its configuration.
- R3: Status is read as four little-endian bytes at 0x10 to 0x13 (line n in byte n>>3, bit n&7); bits for lines 18 to 31 always read as zero.
- R4: With control bit 0 (clear-on-read) set, a read of a status byte clears the bits it returned; with it cleared, a read leaves status unchanged and writing a 1 to a status bit clears that bit.
- R5: An event detected in the same cycle as the read or write that clears its bit leaves the bit set.
- R6: Mask A is four little-endian bytes at 0x08 to 0x0B, a 1 blocks that line from interrupt A; it resets to all lines masked (bytes read 0xFF, 0xFF, 0x03, 0x00) and both interrupts are low after reset.
- R7: With control bit 1 (pending-disable) clear, an event on a masked line is still recorded and raises the interrupt once the line is unmasked; with it set, an event on a line blocked from every active interrupt output is discarded.
- R8: With control bit 2 (exclusive) clear, interrupt B equals interrupt A; with it set, interrupt B is the OR of status AND NOT mask B, mask B being four bytes at 0x0C to 0x0F resetting to all lines masked.
- R9: Interrupt outputs follow status and masks in the same cycle, so a transition presented before a clock edge is visible on the interrupt after that single edge; read data appears on the clock edge that samples the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_in | input | NUM_LINES | Synchronized line levels |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, updated on the edge that samples a read |
| irq_a | output | 1 | Interrupt request for host A |
| irq_b | output | 1 | Interrupt request for host B |

## Verification
A wrong status bit shows up on the interrupt lines in the very cycle it appears, since both outputs are a direct reduction of status against the masks, and on the next status read one cycle after the strobe. A wrong edge or mask configuration is exposed through readback of the configuration registers and through a status byte that gains or lacks a bit after a single transition. A lost event at a clearing read is only visible on the following read of the same byte, so the bench always issues a second read after each overlap case.

// File: rtl/edge_irq_agg_pkg.sv
package edge_irq_agg_pkg;
   localparam int DW = 8;
   localparam int AW = 5;
   localparam int VEC_BYTES = 4;
   localparam int VEC_W = DW * VEC_BYTES;
   localparam int LINES_PER_EDGE_REG = 4;
   localparam int EDGE_FIELD_W = 2;

   localparam logic [AW-1:0] A_EDGE  = 5'h00;
   localparam logic [AW-1:0] A_MASKA = 5'h08;
   localparam logic [AW-1:0] A_MASKB = 5'h0C;
   localparam logic [AW-1:0] A_STAT  = 5'h10;
   localparam logic [AW-1:0] A_CTRL  = 5'h14;

   localparam int CTRL_COR  = 0;
   localparam int CTRL_PEND = 1;
   localparam int CTRL_EXCL = 2;
   localparam int CTRL_W    = 3;
endpackage

// File: rtl/eia_edge_detect.sv
module eia_edge_detect #(
   parameter int N = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pins,
   input  logic [N-1:0] rise_en,
   input  logic [N-1:0] fall_en,
   output logic [N-1:0] edges,
   output logic [N-1:0] prev
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pins;
   end

   for (genvar i = 0; i < N; i++) begin : g_line
      logic up, down;
      assign up       = pins[i] & ~prev_q[i];
      assign down     = ~pins[i] & prev_q[i];
      assign edges[i] = (rise_en[i] & up) | (fall_en[i] & down);
   end

   assign prev = prev_q;
endmodule

// File: rtl/eia_regs.sv
module eia_regs
   import edge_irq_agg_pkg::*;
#(
   parameter int N = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic [N-1:0]  status_in,
   output logic [N-1:0]  rise_en,
   output logic [N-1:0]  fall_en,
   output logic [N-1:0]  mask_a,
   output logic [N-1:0]  mask_b,
   output logic          cor,
   output logic          pend_dis,
   output logic          excl,
   output logic [N-1:0]  clr
);
   localparam int EDGE_REGS = (N + LINES_PER_EDGE_REG - 1) / LINES_PER_EDGE_REG;

   logic [DW-1:0]     edge_cfg_q [EDGE_REGS];
   logic [N-1:0]      mask_a_q, mask_b_q, mask_a_d, mask_b_d;
   logic [CTRL_W-1:0] ctrl_q;
   logic [DW-1:0]     rdata_q, rd_val;
   logic              rd_stb, wr_stb;
   logic [VEC_W-1:0]  stat_v, ma_v, mb_v;

   assign rd_stb = sel & ~wr;
   assign wr_stb = sel & wr;

   for (genvar e = 0; e < EDGE_REGS; e++) begin : g_edge_reg
      always_ff @(posedge clk) begin
         if (!rst_n) edge_cfg_q[e] <= '0;
         else if (wr_stb && addr == AW'(int'(A_EDGE) + e)) edge_cfg_q[e] <= wdata;
      end
   end

   always_comb begin
      for (int i = 0; i < N; i++) begin
         rise_en[i] = edge_cfg_q[i / LINES_PER_EDGE_REG][(i % LINES_PER_EDGE_REG) * EDGE_FIELD_W + 1];
         fall_en[i] = edge_cfg_q[i / LINES_PER_EDGE_REG][(i % LINES_PER_EDGE_REG) * EDGE_FIELD_W];
      end
   end

   always_comb begin
      mask_a_d = mask_a_q;
      mask_b_d = mask_b_q;
      clr      = '0;
      for (int i = 0; i < N; i++) begin
         if (wr_stb && addr == AW'(int'(A_MASKA) + i / DW)) mask_a_d[i] = wdata[i % DW];
         if (wr_stb && addr == AW'(int'(A_MASKB) + i / DW)) mask_b_d[i] = wdata[i % DW];
         if (addr == AW'(int'(A_STAT) + i / DW)) begin
            if (rd_stb && ctrl_q[CTRL_COR])                  clr[i] = 1'b1;
            if (wr_stb && !ctrl_q[CTRL_COR] && wdata[i % DW]) clr[i] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_a_q <= '1;
         mask_b_q <= '1;
         ctrl_q   <= '0;
      end else begin
         mask_a_q <= mask_a_d;
         mask_b_q <= mask_b_d;
         if (wr_stb && addr == A_CTRL) ctrl_q <= wdata[CTRL_W-1:0];
      end
   end

   assign stat_v = VEC_W'(status_in);
   assign ma_v   = VEC_W'(mask_a_q);
   assign mb_v   = VEC_W'(mask_b_q);

   always_comb begin
      rd_val = '0;
      for (int e = 0; e < EDGE_REGS; e++)
         if (addr == AW'(int'(A_EDGE) + e)) rd_val = edge_cfg_q[e];
      for (int b = 0; b < VEC_BYTES; b++) begin
         if (addr == AW'(int'(A_MASKA) + b)) rd_val = ma_v[b*DW +: DW];
         if (addr == AW'(int'(A_MASKB) + b)) rd_val = mb_v[b*DW +: DW];
         if (addr == AW'(int'(A_STAT) + b))  rd_val = stat_v[b*DW +: DW];
      end
      if (addr == A_CTRL) rd_val = DW'(ctrl_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata_q <= '0;
      else if (rd_stb) rdata_q <= rd_val;
   end

   assign rdata    = rdata_q;
   assign mask_a   = mask_a_q;
   assign mask_b   = mask_b_q;
   assign cor      = ctrl_q[CTRL_COR];
   assign pend_dis = ctrl_q[CTRL_PEND];
   assign excl     = ctrl_q[CTRL_EXCL];
endmodule

// File: rtl/eia_status.sv
module eia_status #(
   parameter int N = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] edges,
   input  logic [N-1:0] mask_a,
   input  logic [N-1:0] mask_b,
   input  logic         pend_dis,
   input  logic         excl,
   input  logic [N-1:0] clr,
   output logic [N-1:0] accepted,
   output logic [N-1:0] status
);
   logic [N-1:0] reach, status_q;

   assign reach    = ~mask_a | (excl ? ~mask_b : '0);
   assign accepted = pend_dis ? (edges & reach) : edges;

   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & ~clr) | accepted;
   end

   assign status = status_q;
endmodule

// File: rtl/eia_irq_route.sv
module eia_irq_route #(
   parameter int N = 18,
   parameter bit REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] status,
   input  logic [N-1:0] mask_a,
   input  logic [N-1:0] mask_b,
   input  logic         excl,
   output logic         irq_a,
   output logic         irq_b
);
   logic req_a, req_b;

   assign req_a = |(status & ~mask_a);
   assign req_b = excl ? |(status & ~mask_b) : req_a;

   if (REG_OUT) begin : g_reg
      logic a_q, b_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
         end else begin
            a_q <= req_a;
            b_q <= req_b;
         end
      end
      assign irq_a = a_q;
      assign irq_b = b_q;
   end else begin : g_comb
      assign irq_a = req_a;
      assign irq_b = req_b;
   end
endmodule

// File: rtl/edge_irq_agg.sv
module edge_irq_agg
   import edge_irq_agg_pkg::*;
#(
   parameter int NUM_LINES   = 18,
   parameter bit REG_IRQ_OUT = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] pins_in,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [AW-1:0]        bus_addr,
   input  logic [DW-1:0]        bus_wdata,
   output logic [DW-1:0]        bus_rdata,
   output logic                 irq_a,
   output logic                 irq_b
);
   initial begin
      assert (NUM_LINES >= DW && NUM_LINES <= VEC_W)
         else $error("NUM_LINES must lie between one byte and the status vector width");
   end

   logic [NUM_LINES-1:0] rise_en, fall_en, edges_w, prev_w;
   logic [NUM_LINES-1:0] mask_a_w, mask_b_w, clr_w, accepted_w, status_w;
   logic                 cor_w, pend_w, excl_w;

   eia_edge_detect #(.N(NUM_LINES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins    (pins_in),
      .rise_en (rise_en),
      .fall_en (fall_en),
      .edges   (edges_w),
      .prev    (prev_w)
   );

   eia_regs #(.N(NUM_LINES)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (bus_sel),
      .wr        (bus_wr),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .rdata     (bus_rdata),
      .status_in (status_w),
      .rise_en   (rise_en),
      .fall_en   (fall_en),
      .mask_a    (mask_a_w),
      .mask_b    (mask_b_w),
      .cor       (cor_w),
      .pend_dis  (pend_w),
      .excl      (excl_w),
      .clr       (clr_w)
   );

   eia_status #(.N(NUM_LINES)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .edges    (edges_w),
      .mask_a   (mask_a_w),
      .mask_b   (mask_b_w),
      .pend_dis (pend_w),
      .excl     (excl_w),
      .clr      (clr_w),
      .accepted (accepted_w),
      .status   (status_w)
   );

   eia_irq_route #(.N(NUM_LINES), .REG_OUT(REG_IRQ_OUT)) u_route (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (status_w),
      .mask_a (mask_a_w),
      .mask_b (mask_b_w),
      .excl   (excl_w),
      .irq_a  (irq_a),
      .irq_b  (irq_b)
   );
endmodule

// File: rtl/eia_checker.sv
module eia_checker
   import edge_irq_agg_pkg::*;
#(
   parameter int N = 18
) (
   input logic          clk,
   input logic          rst_n,
   input logic [N-1:0]  pins_in,
   input logic [N-1:0]  prev_w,
   input logic [N-1:0]  status_w,
   input logic [N-1:0]  accepted_w,
   input logic          bus_sel,
   input logic          bus_wr,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] bus_rdata,
   input logic          cor_w,
   input logic          excl_w,
   input logic          irq_a,
   input logic          irq_b
);
   // R2: no transition at an edge means no new status bit after it
   a_r2_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
      (pins_in == prev_w) |=> ((status_w & ~$past(status_w)) == '0));

   // R3: the top status byte always reads zero
   a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == A_STAT + 5'd3) |=> (bus_rdata == '0));

   // R4: clear-on-read empties byte 0 when no new event lands there
   a_r4_cor_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == A_STAT && cor_w && accepted_w[DW-1:0] == '0)
      |=> (status_w[DW-1:0] == '0));

   // R5: every accepted event is present in status after the edge
   a_r5_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (|accepted_w) |=> ((status_w & $past(accepted_w)) == $past(accepted_w)));

   // R8: with exclusive mode off, interrupt B mirrors interrupt A
   a_r8_b_mirrors_a: assert property (@(posedge clk) disable iff (!rst_n)
      (!excl_w && !$past(excl_w)) |-> (irq_b == irq_a));
endmodule

bind edge_irq_agg eia_checker #(.N(NUM_LINES)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .pins_in    (pins_in),
   .prev_w     (prev_w),
   .status_w   (status_w),
   .accepted_w (accepted_w),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .cor_w      (cor_w),
   .excl_w     (excl_w),
   .irq_a      (irq_a),
   .irq_b      (irq_b)
);

// File: tb/edge_irq_agg_tb_top.sv
`timescale 1ns/1ps
module edge_irq_agg_tb_top;
   localparam int N = 18;
   localparam logic [4:0] EDG = 5'h00, MKA = 5'h08, MKB = 5'h0C, STA = 5'h10, CTL = 5'h14;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pins = '0;
   logic         sel = 1'b0, wr = 1'b0;
   logic [4:0]   addr = '0;
   logic [7:0]   wdata = '0;
   logic [7:0]   rdata;
   logic         irq_a, irq_b;

   int total = 0, failed = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       resp_v = 1'b0;

   always #4 clk = ~clk;

   edge_irq_agg dut_i (
      .clk(clk), .rst_n(rst_n), .pins_in(pins),
      .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
      .bus_rdata(rdata), .irq_a(irq_a), .irq_b(irq_b)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   endtask

   // monitor: pops the expected read value for each response
   always @(posedge clk) resp_v <= sel & ~wr;
   always @(negedge clk) begin
      if (resp_v) begin
         if (exp_q.size() == 0) check(1, 0, "scoreboard underflow");
         else check(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); sel = 1'b0; wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [4:0] a, input logic [7:0] e, input string tag);
      @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk); sel = 1'b0;
   endtask

   task automatic rd_with_pins(input logic [4:0] a, input logic [7:0] e, input string tag,
                               input logic [N-1:0] p);
      @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a; pins = p;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk); sel = 1'b0;
   endtask

   task automatic set_pins(input logic [N-1:0] p);
      @(negedge clk); pins = p;
   endtask

   task automatic chk_irq(input logic ea, input logic eb, input string tag);
      check(irq_a, ea, {tag, " irq_a"});
      check(irq_b, eb, {tag, " irq_b"});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 reset state
      chk_irq(0, 0, "R6 reset");
      rd_reg(MKA,        8'hFF, "R6 mask A byte0 reset");
      rd_reg(MKA + 5'd2, 8'h03, "R6 mask A byte2 reset");
      rd_reg(MKA + 5'd3, 8'h00, "R3 mask A byte3 zero");
      rd_reg(STA,        8'h00, "R3 status reset");
      // configuration: clear-on-read, line0 rise, line1 fall, line2 both, line3 none, line17 rise
      wr_reg(CTL, 8'h01);
      wr_reg(EDG, 8'h36);
      wr_reg(EDG + 5'd4, 8'h08);
      rd_reg(EDG, 8'h36, "R1 edge readback");
      wr_reg(MKA, 8'h00); wr_reg(MKA + 5'd1, 8'h00); wr_reg(MKA + 5'd2, 8'h00);
      // R1 rising on line 0, R9 timing
      set_pins(18'h00001);
      chk_irq(0, 0, "R9 before edge");
      @(negedge clk);
      chk_irq(1, 1, "R9 after one edge");
      rd_reg(STA, 8'h01, "R1 rising line0");
      rd_reg(STA, 8'h00, "R4 cor cleared");
      chk_irq(0, 0, "R4 irq after clear");
      // R1 falling-only line 1
      set_pins(18'h00003);
      rd_reg(STA, 8'h00, "R1 falling-only ignores rise");
      set_pins(18'h00001);
      rd_reg(STA, 8'h02, "R1 falling line1");
      // R1 both on line 2
      set_pins(18'h00005);
      rd_reg(STA, 8'h04, "R1 both rise line2");
      set_pins(18'h00001);
      rd_reg(STA, 8'h04, "R1 both fall line2");
      // R1 none on line 3
      set_pins(18'h00009);
      set_pins(18'h00001);
      rd_reg(STA, 8'h00, "R1 disabled line3");
      // R3 line 17
      set_pins(18'h20001);
      rd_reg(STA + 5'd2, 8'h02, "R3 line17 in byte2");
      rd_reg(STA + 5'd3, 8'h00, "R3 byte3 zero");
      rd_reg(STA + 5'd2, 8'h00, "R4 byte2 cleared");
      // R2 steady high levels
      repeat (5) @(negedge clk);
      rd_reg(STA,        8'h00, "R2 steady byte0");
      rd_reg(STA + 5'd2, 8'h00, "R2 steady byte2");
      // R5 edge on clearing read
      set_pins(18'h20000);
      rd_with_pins(STA, 8'h00, "R5 read during edge", 18'h20001);
      rd_reg(STA, 8'h01, "R5 edge kept");
      set_pins(18'h20004);
      rd_with_pins(STA, 8'h04, "R5 read set bit", 18'h20000);
      rd_reg(STA, 8'h04, "R5 second edge kept");
      rd_reg(STA, 8'h00, "R5 then cleared");
      // R4 write-one-to-clear mode
      wr_reg(CTL, 8'h00);
      set_pins(18'h20001);
      rd_reg(STA, 8'h01, "R4 no cor read1");
      rd_reg(STA, 8'h01, "R4 no cor read2");
      chk_irq(1, 1, "R4 irq held");
      wr_reg(STA, 8'h01);
      rd_reg(STA, 8'h00, "R4 w1c");
      // R7 pending kept while masked
      wr_reg(CTL, 8'h01);
      wr_reg(MKA, 8'h01);
      set_pins(18'h20000);
      set_pins(18'h20001);
      @(negedge clk);
      chk_irq(0, 0, "R7 masked event");
      wr_reg(MKA, 8'h00);
      chk_irq(1, 1, "R7 unmask raises");
      rd_reg(STA, 8'h01, "R7 pending status");
      // R7 pending disabled
      wr_reg(CTL, 8'h03);
      wr_reg(MKA, 8'h01);
      set_pins(18'h20000);
      set_pins(18'h20001);
      wr_reg(MKA, 8'h00);
      chk_irq(0, 0, "R7 pend dis discarded");
      rd_reg(STA, 8'h00, "R7 pend dis status");
      // R8 exclusive routing
      wr_reg(CTL, 8'h05);
      set_pins(18'h20000);
      set_pins(18'h20001);
      @(negedge clk);
      chk_irq(1, 0, "R8 B own mask");
      wr_reg(MKB, 8'h00);
      chk_irq(1, 1, "R8 B unmasked");
      wr_reg(MKA, 8'h01);
      chk_irq(0, 1, "R8 A masked B live");
      rd_reg(MKB,        8'h00, "R8 mask B byte0");
      rd_reg(MKB + 5'd2, 8'h03, "R8 mask B byte2 reset");
      rd_reg(STA, 8'h01, "R8 status");
      chk_irq(0, 0, "R8 cleared");
      // R8 non-exclusive: B follows A even with B unmasked
      wr_reg(CTL, 8'h01);
      set_pins(18'h20000);
      set_pins(18'h20001);
      @(negedge clk);
      chk_irq(0, 0, "R8 B follows A");
      rd_reg(STA, 8'h01, "R8 follow status");
      repeat (2) @(negedge clk);
      check(exp_q.size(), 0, "scoreboard drained");
      summary();
   end
endmodule